// File: doc/BRIEF.md
# Dual-Counter PWM Timer

This block is a register-mapped timer with two counters. Each counter has a control register, a load register and a live count register. Either counter can also run as a plain reloading timer. When both control registers select PWM generation, the two counters drive a single output together. Counter 0 sets the length of each PWM period. Counter 1 sets how long the output stays high at the start of that period.

Each counter counts either up or down, and the interval it produces depends on that direction. The load bit copies the load register into the counter and holds it there. The enable-all bit starts both counters on the same clock edge, so the two intervals begin aligned. Values written to the load registers while the PWM runs take effect only at the next period boundary, when both counters reload together. Software therefore never causes a partial period.

Register access is a single-cycle 32-bit write port and a combinational read port. Accesses are word-aligned at byte addresses. Control bit positions: 0 count-down, 1 generate, 2 PWM, 3 output enable, 4 auto-reload, 5 load, 6 run, 7 enable-all, 8 cascade.

Top module: `dual_pwm_timer`

## Requirements
- R1: A counting-down counter with load value N gives an interval of N+2 cycles. A counting-up counter gives MAX−N+2 cycles, where MAX = 2^CNT_W−1. While running, the count moves by one each cycle towards 0 (down) or MAX (up). It holds that terminal value for one extra cycle and then reloads from its load register.
- R2: In PWM operation with period P and high time H (intervals as in R1, H < P), the output is high for the first H cycles of each P-cycle period and low for the rest. The first period begins in the first cycle in which both counters run.
- R3: If H ≥ P, the output stays low for the whole period.
- R4: While a control register's load bit (bit 5) is set, its count register equals its load register and does not advance, even with run (bit 6) set.
- R5: A load value written while the PWM runs is first used at the next period boundary. The current period keeps its old length and high time.
- R6: Writing a 1 to bit 7 of either control register sets the run bit (bit 6) in both control registers on the same edge. Both counters then start from their load values in the same cycle.
- R7: The output is low unless both control registers have generate (bit 1), PWM (bit 2), output enable (bit 3), auto-reload (bit 4) and run (bit 6) set and load (bit 5) clear, and cascade (bit 8) is clear in control register 0. Writing zero to a control register therefore forces the output low.
- R8: Register byte offsets are 0x00/0x04/0x08 for counter 0 (control, load, count) and 0x10/0x14/0x18 for counter 1. Control register 0 reads back bits 8:0 and control register 1 reads back bits 6:0; bit 7 and all unimplemented bits read 0. A load register keeps CNT_W bits. Count registers read the live count, and writes to them are ignored. Addresses that are unmapped or not word-aligned read 0, and writes to them are ignored.
- R9: After reset, every register reads zero and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| pwmOut | output | 1 | PWM output |

## Verification
A register write takes effect at the clock edge that samples it. The PWM output, the run bits and the count registers therefore show the new state one cycle after the write is presented. The output of a freshly started PWM is high in the cycle right after the enable-all write. A load value written mid-period changes the output only after the current period's last cycle. The bench drives inputs just after an edge and samples one time unit after the following edge. Its reference model advances its period counter on each edge before applying that edge's write. The model thus sees a load written on a boundary edge exactly as the design does, with the old value used for the reload. Reads go through the combinational read port inside the same cycle, before the next edge.

// File: rtl/pwmt_pkg.sv
`timescale 1ns/1ps
package pwmt_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 32;
  localparam int NUM_CNT   = 2;
  localparam int CTRL_BITS = 9;

  // control bit positions
  localparam int CB_DOWN = 0;
  localparam int CB_GEN  = 1;
  localparam int CB_PWM  = 2;
  localparam int CB_GOUT = 3;
  localparam int CB_AUTO = 4;
  localparam int CB_LOAD = 5;
  localparam int CB_RUN  = 6;
  localparam int CB_ALL  = 7;
  localparam int CB_CASC = 8;

  typedef enum logic [2:0] {
    RG_CTRL0 = 3'd0, RG_LOAD0 = 3'd1, RG_CNT0 = 3'd2,
    RG_CTRL1 = 3'd4, RG_LOAD1 = 3'd5, RG_CNT1 = 3'd6
  } regSel_e;

  typedef struct packed {
    logic run;       // advance this cycle
    logic hold;      // copy load value, do not advance
    logic down;      // count direction
    logic autoRel;   // reload after terminal hold
    logic sync;      // park at terminal, wait for forceRel
    logic forceRel;  // reload now (period boundary)
  } cntStrobe_t;
endpackage

// File: rtl/pwmt_counter.sv
`timescale 1ns/1ps
module pwmt_counter import pwmt_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  cntStrobe_t   stb,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam logic [W-1:0] MAXV = '1;

  logic pend, parked, atTerm, active, selfRel;

  assign atTerm  = stb.down ? (cnt == '0) : (cnt == MAXV);
  assign active  = stb.run && !parked;
  assign expire  = active && pend;
  assign selfRel = expire && stb.autoRel && !stb.sync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      pend   <= 1'b0;
      parked <= 1'b0;
    end else if (stb.hold || stb.forceRel) begin
      cnt    <= loadVal;
      pend   <= 1'b0;
      parked <= 1'b0;
    end else if (active) begin
      if (pend) begin
        pend <= 1'b0;
        if (selfRel) cnt <= loadVal;
        else         parked <= 1'b1;
      end else if (atTerm) begin
        pend <= 1'b1;
      end else begin
        cnt <= stb.down ? cnt - 1'b1 : cnt + 1'b1;
      end
    end
  end

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !pend && !atTerm && !stb.hold && !stb.forceRel)
      |=> (cnt == ($past(stb.down) ? $past(cnt) - W'(1) : $past(cnt) + W'(1))));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.hold |=> (cnt == $past(loadVal)));

  // R5
  jump_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((cnt != $past(cnt)) && (cnt != $past(cnt) + W'(1)) && (cnt != $past(cnt) - W'(1)))
      |-> (cnt == $past(loadVal)));
endmodule

// File: rtl/pwmt_ctrl.sv
`timescale 1ns/1ps
module pwmt_ctrl import pwmt_pkg::*; #(
  parameter int W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  input  logic [NUM_CNT-1:0][W-1:0] cntVal,
  input  logic [NUM_CNT-1:0]        expire,
  output logic [NUM_CNT-1:0][W-1:0] loadVal,
  output cntStrobe_t [NUM_CNT-1:0]  stb,
  output logic                      pwmOut
);
  localparam int IW = W + 2;
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [CTRL_BITS-1:0] MASK0 = ~(CTRL_BITS'(1) << CB_ALL);
  localparam logic [CTRL_BITS-1:0] MASK1 = MASK0 & ~(CTRL_BITS'(1) << CB_CASC);

  logic [NUM_CNT-1:0][CTRL_BITS-1:0] ctrlQ;
  logic [NUM_CNT-1:0][W-1:0]         loadQ;
  logic [NUM_CNT-1:0]                qual;
  logic    hit, pwmOn, wrap0, dutyDone, suppress;
  regSel_e sel;

  function automatic logic [IW-1:0] ivl(input logic [W-1:0] n, input logic dn);
    return dn ? IW'(n) + IW'(2) : IW'(MAXV) - IW'(n) + IW'(2);
  endfunction

  assign sel     = regSel_e'(addr[ADDR_W-1:2]);
  assign hit     = (addr[1:0] == 2'b00);
  assign loadVal = loadQ;
  assign wrap0   = expire[0] && ctrlQ[0][CB_AUTO];

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      qual[i] = ctrlQ[i][CB_GEN] && ctrlQ[i][CB_PWM] && ctrlQ[i][CB_GOUT] &&
                ctrlQ[i][CB_RUN] && ctrlQ[i][CB_AUTO] && !ctrlQ[i][CB_LOAD];
    end
  end
  assign pwmOn = (&qual) && !ctrlQ[0][CB_CASC];

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      stb[i].hold     = ctrlQ[i][CB_LOAD];
      stb[i].run      = ctrlQ[i][CB_RUN] && !ctrlQ[i][CB_LOAD];
      stb[i].down     = ctrlQ[i][CB_DOWN];
      stb[i].autoRel  = ctrlQ[i][CB_AUTO];
      stb[i].sync     = (i == NUM_CNT - 1) && pwmOn;
      stb[i].forceRel = (i == NUM_CNT - 1) && pwmOn && wrap0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      loadQ <= '0;
    end else if (wrEn && hit) begin
      case (sel)
        RG_CTRL0: begin
          ctrlQ[0] <= wrData[CTRL_BITS-1:0] & MASK0;
          if (wrData[CB_ALL]) begin
            ctrlQ[0][CB_RUN] <= 1'b1;
            ctrlQ[1][CB_RUN] <= 1'b1;
          end
        end
        RG_CTRL1: begin
          ctrlQ[1] <= wrData[CTRL_BITS-1:0] & MASK1;
          if (wrData[CB_ALL]) begin
            ctrlQ[0][CB_RUN] <= 1'b1;
            ctrlQ[1][CB_RUN] <= 1'b1;
          end
        end
        RG_LOAD0: loadQ[0] <= wrData[W-1:0];
        RG_LOAD1: loadQ[1] <= wrData[W-1:0];
        default: ;
      endcase
    end
  end

  // high-time phase and long-duty suppression, refreshed at each period start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyDone <= 1'b0;
      suppress <= 1'b0;
    end else begin
      if (ctrlQ[0][CB_LOAD] || ctrlQ[1][CB_LOAD] || (pwmOn && wrap0))
        dutyDone <= 1'b0;
      else if (pwmOn && expire[1])
        dutyDone <= 1'b1;
      if (ctrlQ[0][CB_LOAD] || (pwmOn && wrap0))
        suppress <= ivl(loadQ[1], ctrlQ[1][CB_DOWN]) >= ivl(loadQ[0], ctrlQ[0][CB_DOWN]);
    end
  end

  assign pwmOut = pwmOn && !suppress && !dutyDone;

  always_comb begin
    rdData = '0;
    if (hit) begin
      case (sel)
        RG_CTRL0: rdData[CTRL_BITS-1:0] = ctrlQ[0];
        RG_CTRL1: rdData[CTRL_BITS-1:0] = ctrlQ[1];
        RG_LOAD0: rdData[W-1:0] = loadQ[0];
        RG_LOAD1: rdData[W-1:0] = loadQ[1];
        RG_CNT0:  rdData[W-1:0] = cntVal[0];
        RG_CNT1:  rdData[W-1:0] = cntVal[1];
        default: ;
      endcase
    end
  end

  // R6
  enall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && hit && (sel == RG_CTRL0 || sel == RG_CTRL1) && wrData[CB_ALL])
      |=> (ctrlQ[0][CB_RUN] && ctrlQ[1][CB_RUN]));
endmodule

// File: rtl/dual_pwm_timer.sv
`timescale 1ns/1ps
module dual_pwm_timer import pwmt_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              pwmOut
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [NUM_CNT-1:0][CNT_W-1:0] loadVal;
  logic [NUM_CNT-1:0]            expire;
  cntStrobe_t [NUM_CNT-1:0]      stb;

  pwmt_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cntVal(cntVal), .expire(expire), .loadVal(loadVal),
    .stb(stb), .pwmOut(pwmOut)
  );

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    pwmt_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rstN(rstN), .stb(stb[gi]), .loadVal(loadVal[gi]),
      .cnt(cntVal[gi]), .expire(expire[gi])
    );
  end
endmodule

// File: tb/dual_pwm_timer_test.sv
`timescale 1ns/1ps
module dual_pwm_timer_test;
  localparam int W    = 8;
  localparam int MAXC = 255;
  localparam logic [4:0] A_C0 = 5'h00, A_L0 = 5'h04, A_N0 = 5'h08;
  localparam logic [4:0] A_C1 = 5'h10, A_L1 = 5'h14, A_N1 = 5'h18;
  localparam logic [31:0] F_DN = 1, F_GEN = 2, F_PWM = 4, F_GO = 8, F_AU = 16;
  localparam logic [31:0] F_LD = 32, F_RUN = 64, F_ALL = 128, F_CAS = 256;
  localparam logic [31:0] F_BASE = F_GEN | F_PWM | F_GO | F_AU;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wrData = '0, rdData, v;
  logic pwmOut;

  int checks = 0, errors = 0;
  int shLd0 = 0, shLd1 = 0, k = 0, P = 2, H = 2;
  bit shDn0 = 0, shDn1 = 0, mRun = 0;
  string curReq = "R9";

  always #2.5 clk = ~clk;

  dual_pwm_timer #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  function automatic int ivl(int n, bit dn);
    return dn ? n + 2 : MAXC - n + 2;
  endfunction

  function automatic int expCnt(int n, bit dn, int j);
    int m = j % ivl(n, dn);
    if (dn) return (m <= n) ? n - m : 0;
    return (m <= MAXC - n) ? n + m : MAXC;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock; model advances on the edge before this edge's write is applied
  task automatic step(bit startNow, bit stopNow);
    @(posedge clk);
    if (stopNow) mRun = 0;
    else if (startNow) begin
      mRun = 1; k = 0; P = ivl(shLd0, shDn0); H = ivl(shLd1, shDn1);
    end else if (mRun) begin
      k++;
      if (k == P) begin k = 0; P = ivl(shLd0, shDn0); H = ivl(shLd1, shDn1); end
    end
    #1;
    check((mRun && H >= P) ? "R3" : curReq, {31'b0, pwmOut},
          {31'b0, (mRun && H < P && k < H)}, "pwm output");
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, bit startNow = 0, bit stopNow = 0);
    wrEn = 1; addr = a; wrData = d;
    step(startNow, stopNow);
    if (a == A_L0) shLd0 = int'(d & 32'hFF);
    if (a == A_L1) shLd1 = int'(d & 32'hFF);
    wrEn = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] val);
    addr = a; #0.5; val = rdData;
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) step(0, 0);
  endtask

  task automatic startPwm(int l0, bit d0, int l1, bit d1);
    wr(A_C0, 0, 0, 1); wr(A_C1, 0, 0, 1);
    shDn0 = d0; shDn1 = d1;
    wr(A_L0, l0); wr(A_L1, l1);
    wr(A_C0, F_LD | 32'(d0)); wr(A_C1, F_LD | 32'(d1));
    wr(A_C0, F_BASE | 32'(d0));
    wr(A_C1, F_BASE | F_RUN | F_ALL | 32'(d1), 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    // R9 reset state
    check("R9", {31'b0, pwmOut}, 0, "pwm after reset");
    rd(A_C0, v); check("R9", v, 0, "ctrl0 reset");
    rd(A_L0, v); check("R9", v, 0, "load0 reset");
    rd(A_N0, v); check("R9", v, 0, "count0 reset");
    rd(A_C1, v); check("R9", v, 0, "ctrl1 reset");
    rd(A_L1, v); check("R9", v, 0, "load1 reset");
    rd(A_N1, v); check("R9", v, 0, "count1 reset");

    // R8 register map
    curReq = "R8";
    wr(A_C0, 32'hFFFF_FF7F); rd(A_C0, v); check("R8", v, 32'h17F, "ctrl0 readback");
    wr(A_C1, 32'hFFFF_FF7F); rd(A_C1, v); check("R8", v, 32'h7F, "ctrl1 readback");
    wr(A_L0, 32'hFFFF_FFFF); rd(A_L0, v); check("R8", v, 32'hFF, "load0 width");
    wr(A_C0, 0); wr(A_C1, 0);
    wr(A_N0, 32'h5); rd(A_N0, v); check("R8", v, 32'hFF, "count write ignored");
    wr(5'h05, 32'h3); rd(A_L0, v); check("R8", v, 32'hFF, "misaligned write ignored");
    rd(5'h01, v); check("R8", v, 0, "misaligned read");
    rd(5'h0C, v); check("R8", v, 0, "unmapped read");

    // R6 enable-all sets both run bits
    wr(A_C1, F_ALL);
    rd(A_C0, v); check("R6", v, F_RUN, "ctrl0 run via enable-all");
    rd(A_C1, v); check("R6", v, F_RUN, "ctrl1 run via enable-all");
    wr(A_C0, 0); wr(A_C1, 0);

    // R4 hold, R1 down-count sequence on counter 0
    curReq = "R1";
    wr(A_L0, 2); wr(A_C0, F_LD | F_RUN | F_AU | F_DN);
    for (int i = 0; i < 3; i++) begin
      step(0, 0); rd(A_N0, v); check("R4", v, 2, "count held by load bit");
    end
    wr(A_C0, F_RUN | F_AU | F_DN);
    for (int j = 0; j < 10; j++) begin
      if (j > 0) step(0, 0);
      rd(A_N0, v); check("R1", v, 32'(expCnt(2, 1, j)), "down count sequence");
    end
    wr(A_C0, 0);
    // R1 up-count sequence on counter 1
    wr(A_L1, 253); wr(A_C1, F_LD | F_RUN | F_AU);
    step(0, 0); rd(A_N1, v); check("R4", v, 253, "count1 held by load bit");
    wr(A_C1, F_RUN | F_AU);
    for (int j = 0; j < 10; j++) begin
      if (j > 0) step(0, 0);
      rd(A_N1, v); check("R1", v, 32'(expCnt(253, 0, j)), "up count sequence");
    end
    wr(A_C1, 0);

    // R2/R6 PWM down/down with aligned start
    curReq = "R2";
    startPwm(20, 1, 5, 1);
    rd(A_N0, v); check("R6", v, 20, "period counter at start");
    rd(A_N1, v); check("R6", v, 5, "high counter at start");
    step(0, 0);
    rd(A_N0, v); check("R6", v, 19, "period counter aligned");
    rd(A_N1, v); check("R6", v, 4, "high counter aligned");
    runCycles(70);
    // R1/R2 up/up and mixed directions
    curReq = "R1";
    startPwm(240, 0, 250, 0); runCycles(60);
    startPwm(8, 1, 252, 0); runCycles(40);
    // R3 equal and longer high time, then one cycle shorter
    curReq = "R2";
    startPwm(6, 1, 6, 1); runCycles(30);
    startPwm(6, 1, 9, 1); runCycles(30);
    startPwm(6, 1, 5, 1); runCycles(30);
    // R5 new values at next boundary
    curReq = "R5";
    startPwm(10, 1, 3, 1); runCycles(5);
    wr(A_L0, 4); wr(A_L1, 0); runCycles(40);
    wr(A_L0, 12); runCycles(40);
    // R7 qualification
    curReq = "R7";
    startPwm(10, 1, 3, 1); runCycles(15);
    wr(A_C0, F_BASE | F_RUN | F_CAS | F_DN, 0, 1); runCycles(15);
    startPwm(10, 1, 3, 1); runCycles(10);
    wr(A_C1, F_GEN | F_PWM | F_AU | F_RUN | F_DN, 0, 1); runCycles(15);
    startPwm(10, 1, 3, 1); runCycles(10);
    wr(A_C0, 0, 0, 1); runCycles(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule